// File: doc/BRIEF.md
# Widening Vector Sum-Reduction Unit

This unit takes one 128-bit vector operand holding packed unsigned integer lanes and adds every active lane into a single scalar. The scalar has twice the lane width and is returned zero-extended in a 128-bit result word. A 2-bit size code selects the lane width: code 0 gives 8-bit lanes, code 1 gives 16-bit lanes and code 2 gives 32-bit lanes. A width bit selects the active operand. When the width bit is 1, the full 128 bits take part. When it is 0, only bits 63:0 take part.

Some size and width combinations are not legal encodings. For those the unit returns no sum and raises an undefined-operation flag instead. The unit is a two-stage pipeline. It accepts one request per cycle with a valid/ready handshake. Every result appears a fixed number of cycles after its request, whatever the lane arrangement and whatever the operand data, so the timing of the unit reveals nothing about the values.

Top module: `vsum_reduce_unit`

## Requirements
- R1: Each lane is read as an unsigned integer. The lane width is 8, 16 or 32 bits for size code 0, 1 or 2. Lane k sits at operand bits [k*width +: width]. The result is the sum of all active lanes.
- R2: With the width bit at 1, all 128 operand bits form lanes. With it at 0, only bits 63:0 form lanes, and bits 127:64 have no effect on the result.
- R3: Size code 3 with either width bit, and size code 2 with the width bit at 0, set rsp_undef to 1 and drive rsp_sum to all zeros. Every other combination gives rsp_undef = 0.
- R4: rsp_sum keeps only the low 16, 32 or 64 bits of the sum, for size code 0, 1 or 2. Every bit above that is 0.
- R5: A request is accepted at a rising clock edge where req_valid and req_ready are both 1. Its result is presented with rsp_valid = 1 after the second rising edge following acceptance. This holds for every legal and illegal encoding and for any data.
- R6: req_ready is 1 whenever rst is 0. Requests accepted on consecutive edges produce results on consecutive cycles, in acceptance order.
- R7: rsp_valid is 0 in any cycle that does not correspond, by the latency in R5, to an accepted request.
- R8: rst is synchronous and active high. It forces rsp_valid to 0 at the next edge and discards any request already in flight. req_ready is 0 while rst is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit can take a request |
| req_operand | input | 128 | Packed lane vector |
| req_size | input | 2 | Lane size code (0: 8-bit, 1: 16-bit, 2: 32-bit, 3: illegal) |
| req_wide | input | 1 | 1: 128-bit operand, 0: low 64 bits only |
| rsp_valid | output | 1 | Result present |
| rsp_sum | output | 128 | Zero-extended truncated lane sum |
| rsp_undef | output | 1 | Request used an illegal encoding |

## Verification
The hardest condition to reach from the ports is an in-flight request being discarded by reset. To reach it, the stimulus accepts a request and raises reset on the next edge, before that request reaches the output. It then confirms that no result appears where one would otherwise be due. Carry paths are driven to their limit with all-ones operands in every legal arrangement. The narrow-operand case is driven with data only in the upper half, so any leak of ignored bits would show up as a nonzero sum.

// File: rtl/vsr_pkg.sv
package vsr_pkg;
  typedef enum logic [1:0] {
    SZ_B   = 2'd0,
    SZ_H   = 2'd1,
    SZ_W   = 2'd2,
    SZ_RSV = 2'd3
  } lane_size_e;
endpackage

// File: rtl/vsr_decode.sv
module vsr_decode
  import vsr_pkg::*;
(
  input  lane_size_e size_i,
  input  logic       wide_i,
  output logic       illegal_o
);
  always_comb begin
    illegal_o = 1'b0;
    if (size_i == SZ_RSV) illegal_o = 1'b1;
    if (size_i == SZ_W && !wide_i) illegal_o = 1'b1;
  end
endmodule

// File: rtl/vsr_lane_unpack.sv
module vsr_lane_unpack #(
  parameter int unsigned OP_W    = 128,
  parameter int unsigned MIN_E   = 8,
  parameter int unsigned N_SIZES = 3,
  localparam int unsigned LANES  = OP_W / MIN_E,
  localparam int unsigned MAX_E  = MIN_E << (N_SIZES - 1)
) (
  input  logic [OP_W-1:0]              op_i,
  input  logic                         wide_i,
  input  logic [1:0]                   size_i,
  output logic [LANES-1:0][MAX_E-1:0]  lanes_o
);
  localparam int unsigned HALF = OP_W / 2;

  logic [OP_W-1:0] op_eff;
  logic [N_SIZES-1:0][LANES-1:0][MAX_E-1:0] cand;

  // narrow operand: upper half forced out before lane slicing
  assign op_eff = wide_i ? op_i : {{HALF{1'b0}}, op_i[HALF-1:0]};

  for (genvar s = 0; s < N_SIZES; s++) begin : g_size
    localparam int unsigned ES  = MIN_E << s;
    localparam int unsigned CNT = OP_W / ES;
    for (genvar i = 0; i < LANES; i++) begin : g_lane
      if (i < CNT) begin : g_used
        assign cand[s][i] = MAX_E'(op_eff[i*ES +: ES]);
      end else begin : g_idle
        assign cand[s][i] = '0;
      end
    end
  end

  always_comb begin
    lanes_o = '0;
    for (int s = 0; s < N_SIZES; s++) begin
      if (32'(size_i) == s) lanes_o = cand[s];
    end
  end
endmodule

// File: rtl/vsr_accum.sv
module vsr_accum #(
  parameter int unsigned OP_W    = 128,
  parameter int unsigned MIN_E   = 8,
  parameter int unsigned N_SIZES = 3,
  localparam int unsigned LANES  = OP_W / MIN_E,
  localparam int unsigned MAX_E  = MIN_E << (N_SIZES - 1),
  localparam int unsigned ACC_W  = MAX_E + $clog2(LANES)
) (
  input  logic [LANES-1:0][MAX_E-1:0] lanes_i,
  input  logic [1:0]                  size_i,
  input  logic                        undef_i,
  output logic [OP_W-1:0]             sum_o
);
  logic [ACC_W-1:0] acc;
  logic [N_SIZES-1:0][OP_W-1:0] keep_mask;

  for (genvar s = 0; s < N_SIZES; s++) begin : g_mask
    localparam int unsigned KEEP = 2 * (MIN_E << s);
    assign keep_mask[s] = (OP_W'(1) << KEEP) - OP_W'(1);
  end

  // fixed-length add: every lane slot is always summed, no data-dependent exit
  always_comb begin
    acc = '0;
    for (int i = 0; i < LANES; i++) acc = acc + ACC_W'(lanes_i[i]);
  end

  always_comb begin
    sum_o = '0;
    for (int s = 0; s < N_SIZES; s++) begin
      if (32'(size_i) == s) sum_o = OP_W'(acc) & keep_mask[s];
    end
    if (undef_i) sum_o = '0;
  end
endmodule

// File: rtl/vsum_reduce_unit.sv
module vsum_reduce_unit
  import vsr_pkg::*;
#(
  parameter int unsigned OP_W    = 128,
  parameter int unsigned MIN_E   = 8,
  parameter int unsigned N_SIZES = 3,
  localparam int unsigned LANES  = OP_W / MIN_E,
  localparam int unsigned MAX_E  = MIN_E << (N_SIZES - 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [OP_W-1:0] req_operand,
  input  logic [1:0]      req_size,
  input  logic            req_wide,
  output logic            rsp_valid,
  output logic [OP_W-1:0] rsp_sum,
  output logic            rsp_undef
);
  logic                        accept;
  logic                        illegal;
  logic [LANES-1:0][MAX_E-1:0] lanes_d;
  logic [OP_W-1:0]             sum_d;

  logic                        s1_valid;
  logic                        s1_undef;
  lane_size_e                  s1_size;
  logic [LANES-1:0][MAX_E-1:0] s1_lanes;

  assign req_ready = !rst;
  assign accept    = req_valid && req_ready;

  vsr_decode u_decode (
    .size_i    (lane_size_e'(req_size)),
    .wide_i    (req_wide),
    .illegal_o (illegal)
  );

  vsr_lane_unpack #(.OP_W(OP_W), .MIN_E(MIN_E), .N_SIZES(N_SIZES)) u_unpack (
    .op_i    (req_operand),
    .wide_i  (req_wide),
    .size_i  (req_size),
    .lanes_o (lanes_d)
  );

  // stage 1: decoded lanes
  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
    end else begin
      s1_valid <= accept;
    end
    if (accept) begin
      s1_undef <= illegal;
      s1_size  <= lane_size_e'(req_size);
      s1_lanes <= lanes_d;
    end
  end

  vsr_accum #(.OP_W(OP_W), .MIN_E(MIN_E), .N_SIZES(N_SIZES)) u_accum (
    .lanes_i (s1_lanes),
    .size_i  (s1_size),
    .undef_i (s1_undef),
    .sum_o   (sum_d)
  );

  // stage 2: registered result
  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
    end else begin
      rsp_valid <= s1_valid;
    end
    if (s1_valid) begin
      rsp_sum   <= sum_d;
      rsp_undef <= s1_undef;
    end
  end

  AST_FIXED_LATENCY: assert property (@(posedge clk) disable iff (rst)
    accept |-> ##2 rsp_valid); // R5

  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $past(accept, 2)); // R7

  AST_UNDEF_NO_SUM: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_undef) |-> (rsp_sum == '0)); // R3

  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_undef) |->
      ((rsp_sum >> (2 * (MIN_E << $past(s1_size)))) == '0)); // R4

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> !rsp_valid); // R8
endmodule

// File: tb/vsum_reduce_unit_tb.sv
`timescale 1ns/1ps
module vsum_reduce_unit_tb_top;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         req_valid = 1'b0;
  logic         req_ready;
  logic [127:0] req_operand = '0;
  logic [1:0]   req_size = 2'd0;
  logic         req_wide = 1'b0;
  logic         rsp_valid;
  logic [127:0] rsp_sum;
  logic         rsp_undef;

  int checks = 0;
  int failures = 0;
  int edges = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  vsum_reduce_unit dut_i (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_operand(req_operand), .req_size(req_size), .req_wide(req_wide),
    .rsp_valid(rsp_valid), .rsp_sum(rsp_sum), .rsp_undef(rsp_undef)
  );

  function automatic bit ref_undef(logic [1:0] sz, logic q);
    return (sz == 2'd3) || (sz == 2'd2 && !q);
  endfunction

  function automatic logic [127:0] ref_sum(logic [127:0] op, logic [1:0] sz, logic q);
    int es = 8 << sz;
    int w  = q ? 128 : 64;
    logic [127:0] acc = '0;
    if (ref_undef(sz, q)) return '0;
    for (int e = 0; e < w / es; e++)
      acc = acc + ((op >> (e * es)) & ((128'd1 << es) - 128'd1));
    return acc & ((128'd1 << (2 * es)) - 128'd1);
  endfunction

  // behavioural model: one entry waiting, one entry presented
  bit           m1_v, mo_v;
  logic [127:0] m1_sum, mo_sum;
  bit           m1_u, mo_u;
  string        m1_tag, mo_tag;

  always @(posedge clk) begin
    edges++;
    if (rst) begin
      m1_v = 0; mo_v = 0;
    end else begin
      mo_v = m1_v; mo_sum = m1_sum; mo_u = m1_u; mo_tag = m1_tag;
      m1_v = req_valid;
      if (req_valid) begin
        m1_sum = ref_sum(req_operand, req_size, req_wide);
        m1_u   = ref_undef(req_size, req_wide);
        m1_tag = m1_u ? "R3" : (!req_wide ? "R2" : (req_size == 2'd0 ? "R4" : "R1"));
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (edges > 0 && !finished) begin
      if (rst) begin
        chk(rsp_valid == 1'b0, "R8", 128'(rsp_valid), 128'd0);
        chk(req_ready == 1'b0, "R8", 128'(req_ready), 128'd0);
      end else begin
        chk(req_ready == 1'b1, "R6", 128'(req_ready), 128'd1);
        chk(rsp_valid == mo_v, mo_v ? "R5" : "R7", 128'(rsp_valid), 128'(mo_v));
        if (mo_v && rsp_valid) begin
          chk(rsp_undef == mo_u, "R3", 128'(rsp_undef), 128'(mo_u));
          chk(rsp_sum == mo_sum, mo_tag, rsp_sum, mo_sum);
        end
      end
    end
  end

  task automatic send(input logic [127:0] op, input logic [1:0] sz, input logic q);
    req_valid = 1'b1; req_operand = op; req_size = sz; req_wide = q;
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #100000;
    failures++;
    checks++;
    $display("FAIL R5 watchdog expired actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    idle(2);
    // R1 R4: all-ones lanes in every legal arrangement, isolated then back-to-back
    for (int s = 0; s < 3; s++)
      for (int q = 0; q < 2; q++) begin
        send({128{1'b1}}, 2'(s), 1'(q));
        idle(3);
      end
    for (int s = 0; s < 4; s++)
      for (int q = 0; q < 2; q++) send({128{1'b1}}, 2'(s), 1'(q));
    idle(3);
    // R3: every illegal encoding with nonzero data
    send(128'h1234_5678_9abc_def0_0fed_cba9_8765_4321, 2'd3, 1'b0);
    send(128'h1234_5678_9abc_def0_0fed_cba9_8765_4321, 2'd3, 1'b1);
    send(128'h1234_5678_9abc_def0_0fed_cba9_8765_4321, 2'd2, 1'b0);
    idle(3);
    // R2: only upper half populated with narrow operand -> zero sum
    for (int s = 0; s < 2; s++) send({{64{1'b1}}, 64'd0}, 2'(s), 1'b0);
    send({64'hdead_beef_0000_0001, 64'h0102_0304_0506_0708}, 2'd0, 1'b0);
    idle(3);
    // R1: counting lane patterns
    send(128'h0f0e_0d0c_0b0a_0908_0706_0504_0302_0100, 2'd0, 1'b1);
    send(128'h0007_0006_0005_0004_0003_0002_0001_0000, 2'd1, 1'b1);
    send(128'h0000_0003_0000_0002_0000_0001_ffff_ffff, 2'd2, 1'b1);
    idle(3);
    // R8: request discarded by reset while in flight
    send({128{1'b1}}, 2'd0, 1'b1);
    rst = 1'b1;
    idle(2);
    rst = 1'b0;
    idle(4);
    // R5 R6: random back-to-back traffic with gaps
    for (int n = 0; n < 400; n++) begin
      if ($urandom_range(0, 3) == 0) idle(1);
      else send({$urandom, $urandom, $urandom, $urandom}, 2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)));
    end
    idle(4);
    finish_run();
  end
endmodule